// File: doc/BRIEF.md
# Address Breakpoint Comparator

This unit watches the address bus of an 8-bit processor with a 16-bit address space. It stops execution at one chosen address. The breakpoint address is held in two byte-wide registers. A third register carries an enable flag and a sticky active flag. All three sit behind a small synchronous register port: writes take effect at the clock edge and reads return data combinationally.

On every bus cycle marked valid, the unit compares the bus address with the stored breakpoint, provided the enable flag is set. An exact 16-bit match sets the active flag, and the flag drives the break request output. Software can also trigger a break without any match by writing 1 to the active flag. In both cases the flag, and with it the request, stays set until software writes 0 to it. Interrupt handling inside the processor is outside this block; the unit only drives the request line.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, both breakpoint address bytes, the enable flag and the active flag are 0, and `brk_req` is low.
- R2: Address 0xFE09 holds breakpoint bits 15:8 and address 0xFE0A holds bits 7:0. Each byte is fully writable and reads back the value last written.
- R3: At address 0xFE0B, bit 7 is the enable flag and bit 6 is the active flag. Bits 5:0 always read 0, and writing them has no effect.
- R4: A bus cycle with `bus_valid` high, the enable flag 1 and `bus_addr` equal to the full 16-bit breakpoint sets the active flag at the next clock edge.
- R5: While the enable flag is 0, no bus address sets the active flag.
- R6: A cycle with `bus_valid` low never sets the active flag, whatever the address.
- R7: An address that differs from the breakpoint in any single bit does not set the active flag.
- R8: Writing 1 to bit 6 of 0xFE0B sets the active flag and raises `brk_req` with no address match.
- R9: The active flag stays set until a write of 0 to bit 6. If a hardware match and a software clear fall in the same cycle, the flag stays set.
- R10: Reads from any address other than the three registers return 0. Writes to such addresses change no register.
- R11: `brk_req` equals the active flag. It is registered: it rises at the clock edge that ends the matching bus cycle, not during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register port address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_addr | input | 16 | Processor bus address being watched |
| bus_valid | input | 1 | Qualifies `bus_addr` for this cycle |
| brk_req | output | 1 | Break request, high while the active flag is set |

## Verification
A wrong breakpoint byte or a wrong flag shows up at the register read port in the same cycle it is addressed. It also shows up on `brk_req` one edge after the next valid bus cycle: either a missed break or a spurious one. A lane comparator with a stuck or inverted bit is exposed by flipping each address bit in turn and by sweeping several breakpoint values. A wrong set/clear priority in the flag logic is caught in the single cycle where a match and a clear coincide. A stale or leaking flag is caught because `brk_req` is sampled right after every clearing write.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;

  typedef struct packed {
    logic en;
    logic act;
  } bkpt_ctrl_t;

  // Next state of the control flags. A hardware hit wins over a software clear.
  function automatic bkpt_ctrl_t ctrl_next(input bkpt_ctrl_t cur,
                                           input logic       we,
                                           input logic       wr_en,
                                           input logic       wr_act,
                                           input logic       hit);
    bkpt_ctrl_t n;
    n.en  = we ? wr_en : cur.en;
    n.act = hit | (we ? wr_act : cur.act);
    return n;
  endfunction

endpackage

// File: rtl/bkpt_decode.sv
`timescale 1ns/1ps
module bkpt_decode #(
  parameter int unsigned        ADDR_W    = 16,
  parameter int unsigned        LANES     = 2,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'hFE09
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  lane_sel,
  output logic              ctrl_sel
);

  // The most significant lane sits at the base address and the lanes descend.
  function automatic logic [ADDR_W-1:0] lane_addr(input int unsigned lane);
    return BASE_ADDR + ADDR_W'(LANES - 1 - lane);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_sel[i] = (addr == lane_addr(i));
  end

  assign ctrl_sel = (addr == BASE_ADDR + ADDR_W'(LANES));

endmodule

// File: rtl/bkpt_addr_regs.sv
`timescale 1ns/1ps
module bkpt_addr_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned BP_W  = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  lane_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [BP_W-1:0]   bp_addr
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q <= '0;
      else if (we && lane_sel[i])
        byte_q <= wdata;
    end

    assign bp_addr[i*DATA_W +: DATA_W] = byte_q;

    // R2: a write to a lane lands exactly in that lane
    a_r2_lane_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && lane_sel[i]) |=> (bp_addr[i*DATA_W +: DATA_W] == $past(wdata)));
  end

  // R10: with no write strobe the breakpoint holds
  a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && $past(rst_n)) |=> $stable(bp_addr));

endmodule

// File: rtl/bkpt_match.sv
`timescale 1ns/1ps
module bkpt_match #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned BP_W  = DATA_W * LANES
) (
  input  logic [BP_W-1:0] bp_addr,
  input  logic [BP_W-1:0] bus_addr,
  input  logic            bus_valid,
  input  logic            armed,
  output logic            hit
);

  function automatic logic lane_equal(input logic [DATA_W-1:0] a,
                                      input logic [DATA_W-1:0] b);
    return ~|(a ^ b);
  endfunction

  logic [LANES-1:0] lane_eq;

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign lane_eq[i] = lane_equal(bp_addr[i*DATA_W +: DATA_W],
                                   bus_addr[i*DATA_W +: DATA_W]);
  end

  assign hit = armed & bus_valid & (&lane_eq);

endmodule

// File: rtl/bkpt_status.sv
`timescale 1ns/1ps
module bkpt_status
  import bkpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       wr_en_bit,
  input  logic       wr_act_bit,
  input  logic       hw_hit,
  output bkpt_ctrl_t ctrl_q,
  output logic       brk_req
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else
      ctrl_q <= ctrl_next(ctrl_q, ctrl_we, wr_en_bit, wr_act_bit, hw_hit);
  end

  assign brk_req = ctrl_q.act;

  // R4: an enabled match raises the request at the next edge
  a_r4_hit_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    hw_hit |=> brk_req);

  // R8: software trigger
  a_r8_sw_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wr_act_bit) |=> brk_req);

  // R9: sticky until an explicit clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !(ctrl_we && !wr_act_bit)) |=> brk_req);

  // R9: hardware set beats a same-cycle software clear
  a_r9_hit_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_hit && ctrl_we && !wr_act_bit) |=> ctrl_q.act);

  // R3: the enable flag follows the written bit
  a_r3_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q.en == $past(wr_en_bit)));

endmodule

// File: rtl/bkpt_unit.sv
`timescale 1ns/1ps
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE09,
  parameter int unsigned       EN_BIT    = 7,
  parameter int unsigned       ACT_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_valid,
  output logic              brk_req
);

  localparam int unsigned       LANES    = ADDR_W / DATA_W;
  localparam logic [ADDR_W-1:0] LAST_REG = BASE_ADDR + ADDR_W'(LANES);

  logic [LANES-1:0]  lane_sel;
  logic              ctrl_sel;
  logic [ADDR_W-1:0] bp_addr;
  logic              hw_hit;
  bkpt_ctrl_t        ctrl_q;

  bkpt_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr(reg_addr), .lane_sel(lane_sel), .ctrl_sel(ctrl_sel)
  );

  bkpt_addr_regs #(
    .DATA_W(DATA_W), .LANES(LANES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .lane_sel(lane_sel),
    .wdata(reg_wdata), .bp_addr(bp_addr)
  );

  bkpt_match #(
    .DATA_W(DATA_W), .LANES(LANES)
  ) u_match (
    .bp_addr(bp_addr), .bus_addr(bus_addr), .bus_valid(bus_valid),
    .armed(ctrl_q.en), .hit(hw_hit)
  );

  bkpt_status u_status (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(reg_we && ctrl_sel),
    .wr_en_bit(reg_wdata[EN_BIT]),
    .wr_act_bit(reg_wdata[ACT_BIT]),
    .hw_hit(hw_hit),
    .ctrl_q(ctrl_q),
    .brk_req(brk_req)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_sel[i])
        reg_rdata = reg_rdata | bp_addr[i*DATA_W +: DATA_W];
    end
    if (ctrl_sel) begin
      reg_rdata[EN_BIT]  = ctrl_q.en;
      reg_rdata[ACT_BIT] = ctrl_q.act;
    end
  end

  // R5: disabled unit never matches
  a_r5_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> !hw_hit);

  // R6: unqualified bus cycles never match
  a_r6_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !hw_hit);

  // R10: addresses outside the window read as zero
  a_r10_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr < BASE_ADDR) || (reg_addr > LAST_REG)) |-> (reg_rdata == '0));

  // R1: flags clear after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (ctrl_q == '0));

endmodule

// File: tb/tb_bkpt_unit.sv
`timescale 1ns/1ps
module tb_bkpt_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] bus_addr;
  logic        bus_valid;
  logic        brk_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [15:0] A_HI = 16'hFE09;
  localparam logic [15:0] A_LO = 16'hFE0A;
  localparam logic [15:0] A_CT = 16'hFE0B;

  always #2.5 clk = ~clk;

  bkpt_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .bus_valid(bus_valid), .brk_req(brk_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic bus(input logic [15:0] a, input logic v);
    bus_addr = a; bus_valid = v;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] bp;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    bus_addr = '0; bus_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_HI, v); chk("R1 hi", {8'h0, v}, 16'h0);
    rd(A_LO, v); chk("R1 lo", {8'h0, v}, 16'h0);
    rd(A_CT, v); chk("R1 ctrl", {8'h0, v}, 16'h0);
    chk("R1 brk_req", {15'h0, brk_req}, 16'h0);

    // R2: every byte value in both lanes
    for (int k = 0; k < 256; k++) begin
      wr(A_HI, 8'(k));
      wr(A_LO, 8'(255 - k));
      rd(A_HI, v); chk("R2 hi", {8'h0, v}, 16'(k));
      rd(A_LO, v); chk("R2 lo", {8'h0, v}, 16'(255 - k));
    end

    // R3: reserved bits ignored, flags at 7 and 6
    wr(A_CT, 8'h3F);
    rd(A_CT, v); chk("R3 reserved", {8'h0, v}, 16'h0);
    chk("R3 no req", {15'h0, brk_req}, 16'h0);
    wr(A_CT, 8'hFF);
    rd(A_CT, v); chk("R3 flags", {8'h0, v}, 16'h00C0);
    wr(A_CT, 8'h00);
    rd(A_CT, v); chk("R3 cleared", {8'h0, v}, 16'h0);

    // R8: software trigger
    wr(A_CT, 8'h40);
    chk("R8 req", {15'h0, brk_req}, 16'h1);
    rd(A_CT, v); chk("R8 ctrl", {8'h0, v}, 16'h0040);
    wr(A_CT, 8'h00);
    chk("R8 cleared", {15'h0, brk_req}, 16'h0);

    // R4 / R11: match and latency
    wr(A_HI, 8'h12); wr(A_LO, 8'h34); wr(A_CT, 8'h80);
    bus_addr = 16'h1234; bus_valid = 1'b1;
    #1 chk("R11 not in same cycle", {15'h0, brk_req}, 16'h0);
    @(negedge clk); bus_valid = 1'b0;
    chk("R4 match req", {15'h0, brk_req}, 16'h1);
    rd(A_CT, v); chk("R11 req equals flag", {8'h0, v}, 16'h00C0);
    wr(A_CT, 8'h80);
    chk("R9 clear", {15'h0, brk_req}, 16'h0);

    // R7: single-bit mismatches
    for (int b = 0; b < 16; b++) begin
      bus(16'h1234 ^ (16'h1 << b), 1'b1);
      chk($sformatf("R7 bit %0d", b), {15'h0, brk_req}, 16'h0);
    end

    // R6: unqualified cycle
    bus(16'h1234, 1'b0);
    chk("R6 invalid", {15'h0, brk_req}, 16'h0);

    // R5: disabled
    wr(A_CT, 8'h00);
    bus(16'h1234, 1'b1);
    chk("R5 disabled", {15'h0, brk_req}, 16'h0);
    wr(A_CT, 8'h80);

    // R9: sticky through unrelated traffic
    bus(16'h1234, 1'b1);
    bus(16'h0000, 1'b1);
    wr(A_HI, 8'h55);
    wr(A_CT, 8'hC0);
    chk("R9 sticky", {15'h0, brk_req}, 16'h1);
    rd(A_CT, v); chk("R9 ctrl", {8'h0, v}, 16'h00C0);
    wr(A_HI, 8'h12);
    // R9: match beats clear in the same cycle
    bus_addr = 16'h1234; bus_valid = 1'b1;
    reg_addr = A_CT; reg_wdata = 8'h80; reg_we = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; reg_we = 1'b0;
    chk("R9 hit beats clear", {15'h0, brk_req}, 16'h1);
    wr(A_CT, 8'h80);
    chk("R9 final clear", {15'h0, brk_req}, 16'h0);

    // R10: outside the window
    wr(16'hFE08, 8'hFF); wr(16'hFE0C, 8'hFF);
    wr(16'h0000, 8'hFF); wr(16'hFFFF, 8'hFF);
    rd(16'hFE08, v); chk("R10 rd FE08", {8'h0, v}, 16'h0);
    rd(16'hFE0C, v); chk("R10 rd FE0C", {8'h0, v}, 16'h0);
    rd(16'h0000, v); chk("R10 rd 0000", {8'h0, v}, 16'h0);
    rd(16'hFFFF, v); chk("R10 rd FFFF", {8'h0, v}, 16'h0);
    rd(A_HI, v); chk("R10 hi kept", {8'h0, v}, 16'h0012);
    rd(A_LO, v); chk("R10 lo kept", {8'h0, v}, 16'h0034);
    rd(A_CT, v); chk("R10 ctrl kept", {8'h0, v}, 16'h0080);
    chk("R10 no req", {15'h0, brk_req}, 16'h0);

    // R4: sweep of breakpoint values
    for (int k = 0; k < 16; k++) begin
      bp = 16'(k * 16'h1111) ^ 16'h0F0F;
      wr(A_HI, bp[15:8]); wr(A_LO, bp[7:0]);
      bus(bp ^ 16'h8000, 1'b1);
      chk("R4 sweep near", {15'h0, brk_req}, 16'h0);
      bus(bp, 1'b1);
      chk("R4 sweep hit", {15'h0, brk_req}, 16'h1);
      wr(A_CT, 8'h80);
      chk("R9 sweep clear", {15'h0, brk_req}, 16'h0);
    end

    done = 1'b1;
    summary();
  end

endmodule